// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port Register Block

This block is a small general-purpose I/O port. Software reaches it through a word-addressed register bus with a single write strobe and a combinational read path. A per-pin configuration register chooses how each pin behaves. An output latch drives the pins. A separate write-only word changes chosen output bits in one bus write, so software never needs a read-modify-write sequence that an interrupt could split. A read-only word returns the pin levels after a two-stage synchronizer.

Only the output mode code turns on a pin's driver. The other codes (input, alternate, analog) are decoded but leave the driver off. The asynchronous active-low reset is released through an internal synchronizer. Every register returns to zero, so all pins start as inputs with their drivers off.

Register map (word index on `bus_addr`, with the byte offset in brackets): 0 [0x00] pin configuration; 4 [0x10] synchronized pin levels; 5 [0x14] output latch; 6 [0x18] atomic set/clear. Indices 1, 2, 3 and 7 are unmapped.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, the configuration word, the output latch, `pin_out` and `pin_oe` are all zero.
- R2: The configuration word at index 0 holds two bits per pin, with pin n in bits 2n+1:2n, and reads back as written. Code 01 sets `pin_oe[n]`. Codes 00 (input), 10 and 11 clear it.
- R3: A write to index 5 loads `bus_wdata[15:0]` into the output latch. `pin_out` shows the new value after that clock edge, and index 5 reads it back.
- R4: A write to index 6 with bit n (0 to 15) set drives output bit n high.
- R5: A write to index 6 with bit n+16 set drives output bit n low.
- R6: Output bits whose set bit and clear bit are both zero in an index 6 write keep their value.
- R7: If one index 6 write requests both set and clear for the same pin, the pin goes high.
- R8: Index 6 always reads as zero.
- R9: Index 4 returns each `pin_in` level two clock edges after it is applied. Writes to index 4 change no state.
- R10: Unmapped indices read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output latch driven to the pads |
| pin_oe | output | 16 | Per-pin output driver enable |

## Verification
The bench sweeps all four codes on every pin, and also mixed configuration words, so a field placed at the wrong offset or a driver enabled by the wrong code shows up at once. Many pairs of latch value and set/clear word are compared with (old & ~clear) | set. A design where clear wins the conflict gives low pins where high ones are expected. A design that writes the whole word into the latch destroys bits whose set and clear bits are zero. The input path is sampled one edge and then two edges after a change, which exposes a missing or extra synchronizer stage. Writes to the input word and to unmapped words are followed by read-backs of every register, so a decoder that aliases addresses corrupts a value the bench can see.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    PM_INPUT  = 2'b00,
    PM_OUTPUT = 2'b01,
    PM_ALT    = 2'b10,
    PM_ANALOG = 2'b11
  } pin_mode_e;

  // Word indices on the register bus (byte offset = index * 4).
  localparam int unsigned IDX_CFG  = 0;
  localparam int unsigned IDX_IN   = 4;
  localparam int unsigned IDX_OUT  = 5;
  localparam int unsigned IDX_ATOM = 6;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign rst_q = stg_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;
endmodule

// File: rtl/gpio_mode_dec.sv
module gpio_mode_dec
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic [2*NPINS-1:0] cfg,
  output logic [NPINS-1:0]   oe
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    pin_mode_e mode;
    assign mode  = pin_mode_e'(cfg[2*g+1:2*g]);
    assign oe[g] = (mode == PM_OUTPUT);
  end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_load,
  input  logic             wr_atom,
  input  logic [NPINS-1:0] set_bits,
  input  logic [NPINS-1:0] clr_bits,
  output logic [NPINS-1:0] q
);
  logic [NPINS-1:0] q_r;
  logic [NPINS-1:0] q_d;
  logic             q_en;

  always_comb begin
    q_en = wr_load | wr_atom;
    q_d  = q_r;
    if (wr_atom)      q_d = (q_r & ~clr_bits) | set_bits; // set wins
    else if (wr_load) q_d = set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  localparam int unsigned CFG_W = 2 * NPINS;
  localparam logic [AW-1:0] A_CFG = AW'(IDX_CFG);
  localparam logic [AW-1:0] A_IN  = AW'(IDX_IN);
  localparam logic [AW-1:0] A_OUT = AW'(IDX_OUT);
  localparam logic [AW-1:0] A_ATM = AW'(IDX_ATOM);

  logic             rst_q;
  logic [CFG_W-1:0] mode_q;
  logic [CFG_W-1:0] mode_d;
  logic             mode_en;
  logic [NPINS-1:0] in_sync;
  logic             wr_load;
  logic             wr_atom;

  gpio_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  // Write decode
  always_comb begin
    mode_en = bus_we && (bus_addr == A_CFG);
    wr_load = bus_we && (bus_addr == A_OUT);
    wr_atom = bus_we && (bus_addr == A_ATM);
    mode_d  = bus_wdata[CFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end

  gpio_mode_dec #(.NPINS(NPINS)) u_dec (
    .cfg (mode_q),
    .oe  (pin_oe)
  );

  gpio_out_latch #(.NPINS(NPINS)) u_out (
    .clk      (clk),
    .rst_n    (rst_q),
    .wr_load  (wr_load),
    .wr_atom  (wr_atom),
    .set_bits (bus_wdata[NPINS-1:0]),
    .clr_bits (bus_wdata[2*NPINS-1:NPINS]),
    .q        (pin_out)
  );

  gpio_in_sync #(.W(NPINS)) u_in (
    .clk   (clk),
    .rst_n (rst_q),
    .din   (pin_in),
    .dout  (in_sync)
  );

  // Read mux; the atomic word and unmapped indices return zero
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG:   bus_rdata[CFG_W-1:0] = mode_q;
      A_IN:    bus_rdata[NPINS-1:0] = in_sync;
      A_OUT:   bus_rdata[NPINS-1:0] = pin_out;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 3
) (
  input logic             clk,
  input logic             rst_q,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pin_out,
  input logic [2*NPINS-1:0] mode_q
);
  localparam logic [AW-1:0] A_IN  = AW'(IDX_IN);
  localparam logic [AW-1:0] A_OUT = AW'(IDX_OUT);
  localparam logic [AW-1:0] A_ATM = AW'(IDX_ATOM);

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == A_OUT) |=> pin_out == $past(bus_wdata[NPINS-1:0]));

  assert_set_high_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == A_ATM) |=>
      (pin_out & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0]));

  assert_clr_low_R5: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == A_ATM) |=>
      (pin_out & $past(bus_wdata[2*NPINS-1:NPINS] & ~bus_wdata[NPINS-1:0])) == '0);

  assert_untouched_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_we && bus_addr == A_ATM) |=>
      ((pin_out ^ $past(pin_out)) &
       ~$past(bus_wdata[NPINS-1:0] | bus_wdata[2*NPINS-1:NPINS])) == '0);

  assert_atom_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_addr == A_ATM) |-> bus_rdata == '0);

  assert_in_two_edges_R9: assert property (@(posedge clk) disable iff (!rst_q)
    (age_q >= 2'd2 && bus_addr == A_IN) |-> bus_rdata[NPINS-1:0] == $past(pin_in, 2));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_q)
    !bus_we |=> ($stable(pin_out) && $stable(mode_q)));
endmodule

bind gpio_port_regs gpio_port_chk #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_q     (rst_q),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .mode_q    (mode_q)
);

// File: tb/tb_gpio_port_regs.sv
`timescale 1ns/1ps
module tb_gpio_port_regs;
  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;
  logic [31:0] lfsr = 32'hACE1_2B3D;

  gpio_port_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] step(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  function automatic logic [15:0] oe_of(input logic [31:0] m);
    logic [15:0] r = '0;
    for (int p = 0; p < 16; p++) r[p] = (m[2*p +: 2] == 2'b01);
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] m;
    logic [15:0] v;
    logic [15:0] exp_out;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = 16'h0000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(3'd0, r); check("R1 cfg", r, 32'h0);
    rd(3'd5, r); check("R1 out latch", r, 32'h0);
    check("R1 pin_out", {16'h0, pin_out}, 32'h0);
    check("R1 pin_oe", {16'h0, pin_oe}, 32'h0);

    // R2 every code on every pin
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 4; c++) begin
        m = 32'(c) << (2*p);
        wr(3'd0, m);
        rd(3'd0, r); check("R2 readback", r, m);
        check("R2 oe single", {16'h0, pin_oe}, {16'h0, (c == 1) ? (16'h1 << p) : 16'h0});
      end
    end
    // R2 mixed words
    for (int i = 0; i < 40; i++) begin
      lfsr = step(lfsr);
      wr(3'd0, lfsr);
      check("R2 oe mixed", {16'h0, pin_oe}, {16'h0, oe_of(lfsr)});
    end
    wr(3'd0, 32'h5555_5555); check("R2 all out", {16'h0, pin_oe}, 32'h0000_FFFF);
    wr(3'd0, 32'h0);         check("R2 all in",  {16'h0, pin_oe}, 32'h0);

    // R3 direct load
    for (int i = 0; i < 20; i++) begin
      lfsr = step(lfsr);
      wr(3'd5, lfsr);
      check("R3 pin_out", {16'h0, pin_out}, {16'h0, lfsr[15:0]});
      rd(3'd5, r); check("R3 readback", r, {16'h0, lfsr[15:0]});
    end

    // R4..R7 targeted
    wr(3'd5, 16'h00F0); wr(3'd6, 32'h0000_0F0F);
    check("R4 set", {16'h0, pin_out}, 32'h0000_0FFF);
    wr(3'd6, 32'h00F0_0000);
    check("R5 clear", {16'h0, pin_out}, 32'h0000_0F0F);
    wr(3'd6, 32'h0);
    check("R6 zero word", {16'h0, pin_out}, 32'h0000_0F0F);
    wr(3'd6, 32'hFFFF_FFFF);
    check("R7 set wins", {16'h0, pin_out}, 32'h0000_FFFF);
    wr(3'd6, 32'hFFFF_0000);
    check("R5 clear all", {16'h0, pin_out}, 32'h0);

    // R4..R7 arithmetic sweep
    for (int i = 0; i < 300; i++) begin
      lfsr = step(lfsr); v = lfsr[15:0];
      wr(3'd5, {16'h0, v});
      lfsr = step(lfsr);
      wr(3'd6, lfsr);
      exp_out = (v & ~lfsr[31:16]) | lfsr[15:0];
      check("R4 R5 R6 R7 atomic", {16'h0, pin_out}, {16'h0, exp_out});
      rd(3'd6, r); check("R8 reads zero", r, 32'h0);
    end

    // R9 input synchronizer latency
    wr(3'd0, 32'h1234_5678);
    wr(3'd5, 32'h0000_A5A5);
    @(negedge clk); pin_in = 16'h0000;
    repeat (3) @(negedge clk);
    pin_in = 16'hC3A5; bus_addr = 3'd4;
    @(negedge clk); rd(3'd4, r); check("R9 one edge", r, 32'h0);
    @(negedge clk); rd(3'd4, r); check("R9 two edges", r, 32'h0000_C3A5);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, r); check("R9 write ignored in", r, 32'h0000_C3A5);
    rd(3'd0, r); check("R9 write ignored cfg", r, 32'h1234_5678);
    rd(3'd5, r); check("R9 write ignored out", r, 32'h0000_A5A5);

    // R10 unmapped indices
    for (int a = 0; a < 8; a++) begin
      if (a == 1 || a == 2 || a == 3 || a == 7) begin
        wr(3'(a), 32'hDEAD_BEEF);
        rd(3'(a), r); check("R10 reads zero", r, 32'h0);
        rd(3'd0, r); check("R10 cfg kept", r, 32'h1234_5678);
        rd(3'd5, r); check("R10 out kept", r, 32'h0000_A5A5);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule